// File: doc/BRIEF.md
# Banked effective address generator

This block turns an addressing request into a 20-bit effective address. It uses a model of memory in which each address is a 16-bit word value with a 4-bit bank extension in front. The block holds four 20-bit pointers: three index pointers and a stack pointer. Each pointer is a 16-bit value plus its 4-bit bank extension. The block also holds the 4-bit bank extension of the program counter.

A request selects one of eight addressing modes, or one of three pointer-add operations. The result is registered and presented one cycle later with a valid strobe.

Index arithmetic works on the full 20-bit pointer, so a carry or borrow out of bit 15 moves the output into the next or previous 64 KB bank. An address calculation never rewrites a stored bank extension. Only the pointer-add operations write back all 20 bits, plus the single post-modify case, which writes back only the low 16 bits of the X pointer.

The 24-bit bus address is the effective address with bits 23:20 copied from bit 19.

Top module: `bank_ea_gen`

## Requirements
- R1: After reset, `ea_valid` is 0, `ea` and `bus_addr` are 0, all four pointers read as 0 and the program bank is 0.
- R2: A request accepted on one clock edge gives `ea_valid` = 1 after that edge. With no request, `ea_valid` is 0 and `ea` keeps its last value.
- R3: `bus_addr[19:0]` equals `ea`, and `bus_addr[23:20]` each equal `ea[19]`.
- R4: When `req_kind` = 0, mode 0 (immediate) gives {program bank, `pc`}. Mode 1 (extended) gives {`ek`, `operand[15:0]`}.
- R5: Mode 2 (8-bit indexed) adds `operand[7:0]`, zero-extended, to the 20-bit pointer chosen by `ptr_sel` (0 = X, 1 = Y, 2 = Z, 3 = SP). Any carry reaches `ea[19:16]`.
- R6: Mode 3 adds `operand[15:0]`, sign-extended, to the chosen 20-bit pointer. Mode 4 adds the full 20-bit `operand` modulo 2^20. Both modes carry and borrow across banks.
- R7: Mode 5 (accumulator offset) adds the accumulator value `operand[15:0]`, sign-extended, to the chosen 20-bit pointer.
- R8: Mode 6 (relative) with `br_taken` = 1 gives {program bank, `pc` + offset} with a 16-bit wrap. The offset is `operand[7:0]` sign-extended when `ptr_sel[0]` = 1, and `operand[15:0]` otherwise. With `br_taken` = 0 the mode gives {program bank, `pc`}.
- R9: Mode 7 (post-modify) ignores `ptr_sel` and outputs the X pointer as it was. It then adds `operand[7:0]`, sign-extended, to the low 16 bits of X with a 16-bit wrap, and leaves the bank of X unchanged.
- R10: Modes 0 to 6 leave all four stored pointers unchanged, including their bank extensions, even when `ea` crosses a bank.
- R11: When `req_kind` = 1, the chosen pointer gets a 20-bit add written back. For `mode[1:0]` = 0 the addend is `operand[7:0]` sign-extended. For 2 it is `operand[7:0]` zero-extended. For 1 or 3 it is `operand[15:0]` sign-extended. `ea` shows the new pointer value.
- R12: `ld_en` writes `ld_val` into pointer `ld_sel`, and `pk_ld` writes `pk_val` into the program bank. Both take effect after the edge and raise no `ea_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 1 | 0 = address mode, 1 = pointer add |
| mode | input | 3 | Addressing mode or add variant |
| ptr_sel | input | 2 | Pointer select (X, Y, Z, SP); bit 0 selects the short relative offset |
| operand | input | 20 | Offset, immediate, accumulator or address word |
| pc | input | 16 | Program counter value |
| ek | input | 4 | Bank extension used by extended mode |
| br_taken | input | 1 | Branch condition for relative mode |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 2 | Pointer to load |
| ld_val | input | 20 | Pointer load value |
| pk_ld | input | 1 | Program bank load strobe |
| pk_val | input | 4 | Program bank load value |
| ea_valid | output | 1 | Result valid, one cycle after the request |
| ea | output | 20 | Effective address |
| bus_addr | output | 24 | Bus address with bits 23:20 copied from bit 19 |

## Verification
The assertions check on every cycle the one-cycle valid timing and the hold of `ea` when there is no request. They also check the copying of bit 19 into the top of the bus address, and the pass-through forms of the immediate, extended and relative-not-taken modes. Only the bench scenarios can show the arithmetic: carries and borrows across bank boundaries, the 16-bit wrap in relative and post-modify modes, and that stored bank extensions stay intact after address calculations. The bench reads each pointer back through a zero-offset indexed request, because this is the only way to see that state at the ports.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    MD_IMM   = 3'd0,
    MD_EXT   = 3'd1,
    MD_IDX8  = 3'd2,
    MD_IDX16 = 3'd3,
    MD_IDX20 = 3'd4,
    MD_ACC   = 3'd5,
    MD_REL   = 3'd6,
    MD_POST  = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    AD_S8  = 2'd0,
    AD_S16 = 2'd1,
    AD_U8  = 2'd2,
    AD_S16B = 2'd3
  } add_var_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  parameter int SEL_W  = 2,
  localparam int AW    = EXT_W + WORD_W
) (
  input  logic             kind,
  input  logic [2:0]       mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [AW-1:0]    operand,
  input  logic [WORD_W-1:0] pc,
  input  logic [EXT_W-1:0] ek,
  input  logic [EXT_W-1:0] pk,
  input  logic             taken,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    xptr,
  output logic [AW-1:0]    ea_nxt,
  output logic             wr_en,
  output logic [SEL_W-1:0] wr_sel,
  output logic [AW-1:0]    wr_val
);
  logic [AW-1:0]     s8, u8, s16, addend;
  logic [WORD_W-1:0] pc_new;

  always_comb begin
    s8     = {{(AW-8){operand[7]}}, operand[7:0]};
    u8     = {{(AW-8){1'b0}}, operand[7:0]};
    s16    = {{(AW-WORD_W){operand[WORD_W-1]}}, operand[WORD_W-1:0]};
    pc_new = pc + (sel[0] ? s8[WORD_W-1:0] : operand[WORD_W-1:0]);
    ea_nxt = '0;
    wr_en  = 1'b0;
    wr_sel = sel;
    wr_val = '0;
    addend = s16;
    if (kind) begin
      unique case (add_var_e'(mode[1:0]))
        AD_S8:   addend = s8;
        AD_U8:   addend = u8;
        default: addend = s16;
      endcase
      wr_val = base + addend;
      wr_en  = 1'b1;
      ea_nxt = wr_val;
    end else begin
      unique case (ea_mode_e'(mode))
        MD_IMM:   ea_nxt = {pk, pc};
        MD_EXT:   ea_nxt = {ek, operand[WORD_W-1:0]};
        MD_IDX8:  ea_nxt = base + u8;
        MD_IDX16: ea_nxt = base + s16;
        MD_IDX20: ea_nxt = base + operand;
        MD_ACC:   ea_nxt = base + s16;
        MD_REL:   ea_nxt = taken ? {pk, pc_new} : {pk, pc};
        MD_POST: begin
          ea_nxt = xptr;
          wr_en  = 1'b1;
          wr_sel = '0;
          wr_val = {xptr[AW-1:WORD_W], xptr[WORD_W-1:0] + s8[WORD_W-1:0]};
        end
        default:  ea_nxt = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int AW    = 20,
  parameter int NPTR  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [AW-1:0]    ld_val,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [AW-1:0]    wr_val,
  output logic [AW-1:0]    ptr_q [NPTR]
);
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic          en;
    logic [AW-1:0] d;

    always_comb begin
      en = 1'b0;
      d  = ptr_q[i];
      if (ld_en && (ld_sel == SEL_W'(i))) begin
        en = 1'b1;
        d  = ld_val;
      end else if (wr_en && (wr_sel == SEL_W'(i))) begin
        en = 1'b1;
        d  = wr_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ptr_q[i] <= '0;
      else if (en) ptr_q[i] <= d;
    end
  end
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen #(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  parameter int BUS_W  = 24,
  parameter int NPTR   = 4,
  localparam int AW    = EXT_W + WORD_W,
  localparam int SEL_W = $clog2(NPTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_kind,
  input  logic [2:0]        mode,
  input  logic [SEL_W-1:0]  ptr_sel,
  input  logic [AW-1:0]     operand,
  input  logic [WORD_W-1:0] pc,
  input  logic [EXT_W-1:0]  ek,
  input  logic              br_taken,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [AW-1:0]     ld_val,
  input  logic              pk_ld,
  input  logic [EXT_W-1:0]  pk_val,
  output logic              ea_valid,
  output logic [AW-1:0]     ea,
  output logic [BUS_W-1:0]  bus_addr
);
  logic [AW-1:0]    ptr_q [NPTR];
  logic [EXT_W-1:0] pk_q;
  logic [AW-1:0]    calc_ea, wr_val, ea_q, ea_d;
  logic             calc_wr, valid_q;
  logic [SEL_W-1:0] wr_sel;

  ea_calc #(.EXT_W(EXT_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_calc (
    .kind    (req_kind),
    .mode    (mode),
    .sel     (ptr_sel),
    .operand (operand),
    .pc      (pc),
    .ek      (ek),
    .pk      (pk_q),
    .taken   (br_taken),
    .base    (ptr_q[ptr_sel]),
    .xptr    (ptr_q[0]),
    .ea_nxt  (calc_ea),
    .wr_en   (calc_wr),
    .wr_sel  (wr_sel),
    .wr_val  (wr_val)
  );

  ptr_bank #(.AW(AW), .NPTR(NPTR), .SEL_W(SEL_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ld_en),
    .ld_sel (ld_sel),
    .ld_val (ld_val),
    .wr_en  (calc_wr && req_valid),
    .wr_sel (wr_sel),
    .wr_val (wr_val),
    .ptr_q  (ptr_q)
  );

  always_comb begin
    ea_d = req_valid ? calc_ea : ea_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q    <= '0;
      valid_q <= 1'b0;
      pk_q    <= '0;
    end else begin
      ea_q    <= ea_d;
      valid_q <= req_valid;
      if (pk_ld) pk_q <= pk_val;
    end
  end

  assign ea_valid = valid_q;
  assign ea       = ea_q;
  assign bus_addr = {{(BUS_W-AW){ea_q[AW-1]}}, ea_q};
endmodule

// File: rtl/ea_chk.sv
module ea_chk #(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  parameter int BUS_W  = 24,
  localparam int AW    = EXT_W + WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_kind,
  input logic [2:0]        mode,
  input logic [AW-1:0]     operand,
  input logic [WORD_W-1:0] pc,
  input logic [EXT_W-1:0]  ek,
  input logic              br_taken,
  input logic [EXT_W-1:0]  pk_q,
  input logic              ea_valid,
  input logic [AW-1:0]     ea,
  input logic [BUS_W-1:0]  bus_addr
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ea_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!ea_valid && $stable(ea))); // R2
  AST_BUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bus_addr[BUS_W-1:AW-1]) == 0) ||
    ($countones(bus_addr[BUS_W-1:AW-1]) == BUS_W-AW+1)); // R3
  AST_IMM_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind && mode == 3'd0) |=> ea == {$past(pk_q), $past(pc)}); // R4
  AST_EXT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind && mode == 3'd1) |=>
      ea == {$past(ek), $past(operand[WORD_W-1:0])}); // R4
  AST_REL_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind && mode == 3'd6) |=> ea[AW-1:WORD_W] == $past(pk_q)); // R8
  AST_REL_NOTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind && mode == 3'd6 && !br_taken) |=>
      ea[WORD_W-1:0] == $past(pc)); // R8
endmodule

bind bank_ea_gen ea_chk #(.EXT_W(EXT_W), .WORD_W(WORD_W), .BUS_W(BUS_W)) u_ea_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .mode      (mode),
  .operand   (operand),
  .pc        (pc),
  .ek        (ek),
  .br_taken  (br_taken),
  .pk_q      (pk_q),
  .ea_valid  (ea_valid),
  .ea        (ea),
  .bus_addr  (bus_addr)
);

// File: tb/tb_bank_ea_gen.sv
module tb_bank_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_kind = 1'b0, br_taken = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptr_sel = '0, ld_sel = '0;
  logic [19:0] operand = '0, ld_val = '0;
  logic [15:0] pc = '0;
  logic [3:0]  ek = '0, pk_val = '0;
  logic        ld_en = 1'b0, pk_ld = 1'b0;
  logic        ea_valid;
  logic [19:0] ea;
  logic [23:0] bus_addr;

  int total = 0;
  int bad = 0;

  logic [19:0] m_ptr [4];
  logic [3:0]  m_pk;
  logic        m_valid;
  logic [19:0] m_ea;

  always #4 clk = ~clk;

  bank_ea_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .mode(mode), .ptr_sel(ptr_sel), .operand(operand), .pc(pc), .ek(ek),
    .br_taken(br_taken), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
    .pk_ld(pk_ld), .pk_val(pk_val), .ea_valid(ea_valid), .ea(ea),
    .bus_addr(bus_addr)
  );

  function automatic logic [19:0] sx8(input logic [7:0] v);
    return 20'(signed'(v));
  endfunction
  function automatic logic [19:0] sx16(input logic [15:0] v);
    return 20'(signed'(v));
  endfunction

  task automatic model_step();
    logic [19:0] b;
    logic [15:0] off;
    b = m_ptr[ptr_sel];
    m_valid = req_valid;
    if (req_valid && req_kind) begin
      if (mode[1:0] == 2'd0)      b = b + sx8(operand[7:0]);
      else if (mode[1:0] == 2'd2) b = b + {12'h0, operand[7:0]};
      else                        b = b + sx16(operand[15:0]);
      m_ptr[ptr_sel] = b;
      m_ea = b;
    end else if (req_valid) begin
      case (mode)
        3'd0: m_ea = {m_pk, pc};
        3'd1: m_ea = {ek, operand[15:0]};
        3'd2: m_ea = b + {12'h0, operand[7:0]};
        3'd3: m_ea = b + sx16(operand[15:0]);
        3'd4: m_ea = b + operand;
        3'd5: m_ea = b + sx16(operand[15:0]);
        3'd6: begin
          off = ptr_sel[0] ? 16'(signed'(operand[7:0])) : operand[15:0];
          m_ea = br_taken ? {m_pk, 16'(pc + off)} : {m_pk, pc};
        end
        default: begin
          m_ea = m_ptr[0];
          m_ptr[0] = {m_ptr[0][19:16], 16'(m_ptr[0][15:0] + 16'(signed'(operand[7:0])))};
        end
      endcase
    end
    if (ld_en) m_ptr[ld_sel] = ld_val;
    if (pk_ld) m_pk = pk_val;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (rst_n) model_step();
    #1;
    total++;
    if (ea_valid !== m_valid || ea !== m_ea ||
        bus_addr !== {{4{m_ea[19]}}, m_ea}) begin
      bad++;
      $display("FAIL %s: valid=%b ea=%h bus=%h expected valid=%b ea=%h bus=%h",
               tag, ea_valid, ea, bus_addr, m_valid, m_ea, {{4{m_ea[19]}}, m_ea});
    end
  endtask

  task automatic req(input string tag, input logic k, input logic [2:0] m,
                     input logic [1:0] s, input logic [19:0] op);
    req_valid = 1'b1; req_kind = k; mode = m; ptr_sel = s; operand = op;
    tick(tag);
    req_valid = 1'b0;
  endtask

  task automatic load(input logic [1:0] s, input logic [19:0] v);
    ld_en = 1'b1; ld_sel = s; ld_val = v;
    tick("R12 load");
    ld_en = 1'b0;
  endtask

  task automatic readback(input string tag);
    for (int i = 0; i < 4; i++) req(tag, 1'b0, 3'd3, 2'(i), 20'h0);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_ptr[i] = '0;
    m_pk = '0; m_valid = 1'b0; m_ea = '0;
    tick("R1 reset");
    tick("R1 reset");
    rst_n = 1'b1;
    tick("R1 idle after reset");
    readback("R1 pointers zero");
    req("R1 bank zero", 1'b0, 3'd0, 2'd0, 20'h0);

    load(2'd0, 20'h2FFF0);
    load(2'd1, 20'h50010);
    load(2'd2, 20'hFFFF8);
    load(2'd3, 20'h10000);
    pk_ld = 1'b1; pk_val = 4'hA; tick("R12 bank load"); pk_ld = 1'b0;
    readback("R12 readback");

    pc = 16'h1234;
    req("R4 immediate", 1'b0, 3'd0, 2'd0, 20'h0);
    ek = 4'h7;
    req("R4 extended", 1'b0, 3'd1, 2'd0, 20'h3BEEF);
    tick("R2 hold");
    tick("R2 hold");

    req("R5 idx8 carry", 1'b0, 3'd2, 2'd0, 20'h00020);
    req("R5 idx8 unsigned", 1'b0, 3'd2, 2'd1, 20'h000FF);
    req("R5 idx8 bit19", 1'b0, 3'd2, 2'd2, 20'h00010);
    req("R6 idx16 borrow", 1'b0, 3'd3, 2'd1, 20'h0FFE0);
    req("R6 idx16 pos", 1'b0, 3'd3, 2'd3, 20'h07FFF);
    req("R6 idx20 wrap", 1'b0, 3'd4, 2'd2, 20'h00010);
    req("R6 idx20 neg", 1'b0, 3'd4, 2'd0, 20'hF0000);
    req("R7 acc pos", 1'b0, 3'd5, 2'd2, 20'h00010);
    req("R7 acc neg", 1'b0, 3'd5, 2'd0, 20'h08000);
    readback("R10 banks kept");

    br_taken = 1'b1; pc = 16'h0005;
    req("R8 rel8 taken", 1'b0, 3'd6, 2'd1, 20'h000F0);
    pc = 16'hFFF0;
    req("R8 rel16 wrap", 1'b0, 3'd6, 2'd0, 20'h00020);
    br_taken = 1'b0;
    req("R8 not taken", 1'b0, 3'd6, 2'd0, 20'h00020);

    req("R9 post modify", 1'b0, 3'd7, 2'd2, 20'h00020);
    req("R9 post modify again", 1'b0, 3'd7, 2'd1, 20'h000F0);
    readback("R9 X low only");

    req("R11 add s8", 1'b1, 3'd0, 2'd1, 20'h00080);
    req("R11 add u8", 1'b1, 3'd2, 2'd2, 20'h000FF);
    req("R11 add s16", 1'b1, 3'd1, 2'd3, 20'h0FFFF);
    req("R11 add s16 alt", 1'b1, 3'd3, 2'd0, 20'h0F000);
    readback("R11 writeback");
    tick("R2 idle");
    tick("R3 idle");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule